// File: doc/BRIEF.md
# Dual-compare 8-bit timer

An 8-bit up-counter that advances on one of several count sources: three taps of a free-running divider on the system clock, or edges of an external clock input after a two-flop synchronizer. Two compare registers watch the counter. When the counter advances onto a compare value, a compare flag is raised and the timer output pin may be driven low, driven high or toggled. When the counter wraps from 0xFF to 0x00, an overflow flag is raised.

Software reaches the block through a simple register bus. Reads are combinational and writes take effect on the clock edge. A flag cannot be set by software. It can only be cleared by a two-step handshake: first read the status register while the flag is 1, then write 0 to that flag's bit. If a hardware set and a valid clear of the same flag land in the same cycle, the set wins.

Top module: `dual_cmp_timer8`

## Requirements
- R1: Register addresses are: 0 counter, 1 compare A, 2 compare B, 3 clock select (bits 2:0), 4 status. After reset, the counter, both compares, the clock select and `tmr_out` are 0, and status reads 0x10.
- R2: Clock-select codes 000 and 100 hold the counter. External edges have no effect under these codes.
- R3: Codes 001, 010 and 011 advance the counter exactly once every 8, 64 and 1024 system clocks.
- R4: Code 101 counts rising edges of `ext_clk`, code 110 counts falling edges and code 111 counts both. The counter updates on the third clock edge after `ext_clk` changes.
- R5: The status layout is: bit 7 compare-B flag, bit 6 compare-A flag, bit 5 overflow flag, bit 4 always reads 1, bits 3:0 output select (read/write).
- R6: A compare flag sets when the counter advances onto that compare's value.
- R7: The overflow flag sets when the counter advances from 0xFF to 0x00.
- R8: Writing 1 to status bits 7:5 never sets a flag.
- R9: A flag clears only if 0 is written to its bit after a status read that returned it as 1, with no status write in between. Writing 0 without that read leaves the flag at 1.
- R10: If a hardware set and a valid clear of the same flag happen in the same cycle, the flag stays 1.
- R11: Output-select bits 3:2 act on a compare-B match and bits 1:0 on a compare-A match. The codes are: 00 keep, 01 drive 0, 10 drive 1, 11 toggle. When both compares match at once, the B code applies unless it is 00, in which case the A code applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ext_clk | input | 1 | External count clock, asynchronous |
| tmr_out | output | 1 | Timer output pin |

## Verification
A wrong divider tap or a wrong source decode shows up as a counter value off by whole counts after ten source periods. A mis-registered synchronizer shows up as a result one edge short. A wrongly armed or disarmed clear handshake is visible on the very next status read, as a flag that survived a legal clear or vanished after an illegal one. A wrong output-select decode flips `tmr_out` on the clock edge that takes the counter onto the compare value, so the pin is wrong one cycle after the match.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPA   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPB   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLKSEL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd4;

  // flag index inside the flag vector; status bit = FLAG_BASE + index
  localparam int unsigned FLAG_N    = 3;
  localparam int unsigned FLAG_BASE = 5;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } out_act_e;

  // new pin level for an output-select code
  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    case (out_act_e'(code))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // status word assembly: flags high, constant one at bit 4, selects low
  function automatic logic [DATA_W-1:0] status_word(input logic [FLAG_N-1:0] flags,
                                                    input logic [3:0] osel);
    return {flags[2], flags[1], flags[0], 1'b1, osel};
  endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int LOG_A = 3,
  parameter int LOG_B = 6,
  parameter int LOG_C = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] ticks
);
  localparam int W = LOG_C;
  localparam int LOGS [3] = '{LOG_A, LOG_B, LOG_C};

  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // the divided bit falls on the edge where its low bits are all ones
  for (genvar i = 0; i < 3; i++) begin : g_tap
    assign ticks[i] = &div_q[LOGS[i]-1:0];
  end
endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_read,
  input  logic sw_write,
  input  logic sw_wbit,
  output logic flag,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (hw_set)                            flag <= 1'b1;
      else if (sw_write && armed && !sw_wbit) flag <= 1'b0;
      if (sw_write)              armed <= 1'b0;
      else if (sw_read && flag)  armed <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_cmp_timer8.sv
module dual_cmp_timer8
  import tmr8_pkg::*;
#(
  parameter int PRE_LOG_A = 3,
  parameter int PRE_LOG_B = 6,
  parameter int PRE_LOG_C = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  output logic              tmr_out
);
  logic [DATA_W-1:0] count, cmp_a, cmp_b, cnt_next;
  logic [2:0]        clk_sel;
  logic [3:0]        out_sel;
  logic [2:0]        pre_ticks;
  logic              ext_rise, ext_fall;
  logic              count_tick;
  logic              wr_count, st_wr, st_rd;
  logic              match_a, match_b, ovf_evt;
  logic [FLAG_N-1:0] hw_set, flags, armed;

  tmr8_prescaler #(.LOG_A(PRE_LOG_A), .LOG_B(PRE_LOG_B), .LOG_C(PRE_LOG_C)) u_pre (
    .clk(clk), .rst_n(rst_n), .ticks(pre_ticks)
  );

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  assign wr_count = bus_wr && (bus_addr == ADR_COUNT);
  assign st_wr    = bus_wr && (bus_addr == ADR_STATUS);
  assign st_rd    = bus_rd && (bus_addr == ADR_STATUS);

  always_comb begin
    case (clk_sel)
      3'b001:  count_tick = pre_ticks[0];
      3'b010:  count_tick = pre_ticks[1];
      3'b011:  count_tick = pre_ticks[2];
      3'b101:  count_tick = ext_rise;
      3'b110:  count_tick = ext_fall;
      3'b111:  count_tick = ext_rise | ext_fall;
      default: count_tick = 1'b0;
    endcase
  end

  assign cnt_next = count + 1'b1;
  assign match_a  = count_tick && !wr_count && (cnt_next == cmp_a);
  assign match_b  = count_tick && !wr_count && (cnt_next == cmp_b);
  assign ovf_evt  = count_tick && !wr_count && (&count);
  assign hw_set   = {match_b, match_a, ovf_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      cmp_a   <= '0;
      cmp_b   <= '0;
      clk_sel <= '0;
      out_sel <= '0;
    end else begin
      if (wr_count)        count <= bus_wdata;
      else if (count_tick) count <= cnt_next;
      if (bus_wr && bus_addr == ADR_CMPA)   cmp_a   <= bus_wdata;
      if (bus_wr && bus_addr == ADR_CMPB)   cmp_b   <= bus_wdata;
      if (bus_wr && bus_addr == ADR_CLKSEL) clk_sel <= bus_wdata[2:0];
      if (st_wr)                            out_sel <= bus_wdata[3:0];
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    tmr8_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set[i]), .sw_read(st_rd),
      .sw_write(st_wr), .sw_wbit(bus_wdata[FLAG_BASE+i]),
      .flag(flags[i]), .armed(armed[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              tmr_out <= 1'b0;
    else if (match_b && out_sel[3:2] != 2'b00) tmr_out <= apply_act(tmr_out, out_sel[3:2]);
    else if (match_a)                        tmr_out <= apply_act(tmr_out, out_sel[1:0]);
  end

  always_comb begin
    case (bus_addr)
      ADR_COUNT:  bus_rdata = count;
      ADR_CMPA:   bus_rdata = cmp_a;
      ADR_CMPB:   bus_rdata = cmp_b;
      ADR_CLKSEL: bus_rdata = {5'b0, clk_sel};
      ADR_STATUS: bus_rdata = status_word(flags, out_sel);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] count,
  input logic       wr_count,
  input logic [2:0] clk_sel,
  input logic       ovf_evt,
  input logic       match_a,
  input logic       match_b,
  input logic [2:0] flags,
  input logic [2:0] armed,
  input logic       st_wr,
  input logic [7:0] wdata,
  input logic       tmr_out
);
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_count && (clk_sel == 3'b000 || clk_sel == 3'b100)) |=> $stable(count));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> (count == $past(count) || count == 8'($past(count) + 8'd1)));

  // R7
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(ovf_evt));

  // R6
  cmpa_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(match_a));

  // R9
  cmpa_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> $past(st_wr && armed[1] && !wdata[6]));

  // R9
  cmpb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[2]) |-> $past(st_wr && armed[2] && !wdata[7]));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]);

  // R11
  pin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_out != $past(tmr_out)) |-> $past(match_a || match_b));
endmodule

bind dual_cmp_timer8 tmr8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .wr_count(wr_count), .clk_sel(clk_sel),
  .ovf_evt(ovf_evt), .match_a(match_a), .match_b(match_b), .flags(flags),
  .armed(armed), .st_wr(st_wr), .wdata(bus_wdata), .tmr_out(tmr_out)
);

// File: tb/sim_dual_cmp_timer8.sv
module sim_dual_cmp_timer8;
  localparam int CLK_NS = 10;
  localparam logic [2:0] A_CNT = 3'd0, A_CA = 3'd1, A_CB = 3'd2, A_CS = 3'd3, A_ST = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, ext_clk = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic tmr_out;
  int checks = 0, failures = 0;

  dual_cmp_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk), .tmr_out(tmr_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic ext_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 status", A_ST, 8'h10);
    rd_chk("R1 count", A_CNT, 8'h00);
    rd_chk("R1 cmpa", A_CA, 8'h00);
    rd_chk("R1 cmpb", A_CB, 8'h00);
    rd_chk("R1 clksel", A_CS, 8'h00);
    chk("R1 tmr_out", {7'b0, tmr_out}, 8'h00);
  endtask

  task automatic t_stop;
    wr(A_CA, 8'hF0); wr(A_CB, 8'hF0);
    wr(A_CS, 8'b000); wr(A_CNT, 8'h33);
    repeat (100) @(posedge clk);
    rd_chk("R2 code000 holds", A_CNT, 8'h33);
    wr(A_CS, 8'b100);
    ext_cycles(3);
    rd_chk("R2 code100 holds", A_CNT, 8'h33);
    wr(A_ST, 8'hEF);
    rd_chk("R8 write ones no set / R5 osel rw", A_ST, 8'h1F);
    wr(A_ST, 8'h00);
    rd_chk("R5 osel cleared", A_ST, 8'h10);
  endtask

  task automatic t_internal;
    int per [3] = '{8, 64, 1024};
    logic [7:0] v;
    for (int c = 0; c < 3; c++) begin
      wr(A_CS, 8'(c + 1));
      wr(A_CNT, 8'h00);
      repeat (10 * per[c]) @(posedge clk);
      rd(A_CNT, v);
      chk($sformatf("R3 divider %0d", per[c]), v, 8'd10);
    end
    wr(A_CS, 8'h00);
  endtask

  task automatic t_ext;
    wr(A_CS, 8'b101); wr(A_CNT, 8'h00); ext_cycles(3);
    rd_chk("R4 rising", A_CNT, 8'd3);
    wr(A_CS, 8'b110); wr(A_CNT, 8'h00); ext_cycles(3);
    rd_chk("R4 falling", A_CNT, 8'd3);
    wr(A_CS, 8'b111); wr(A_CNT, 8'h00); ext_cycles(3);
    rd_chk("R4 both", A_CNT, 8'd6);
    // latency: change just after an edge, count moves on the third edge
    wr(A_CNT, 8'h00);
    @(negedge clk) ext_clk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd_chk("R4 not yet", A_CNT, 8'd0);
    rd_chk("R4 third edge", A_CNT, 8'd1);
    @(negedge clk) ext_clk = 1'b0;
    repeat (4) @(posedge clk);
    wr(A_CS, 8'h00);
  endtask

  task automatic t_cmp_ovf;
    wr(A_CA, 8'd3); wr(A_CB, 8'd5);
    wr(A_CS, 8'b101); wr(A_CNT, 8'h00);
    ext_cycles(3);
    rd_chk("R6 cmpa flag", A_ST, 8'h50);
    ext_cycles(2);
    rd_chk("R6 cmpb flag", A_ST, 8'hD0);
    wr(A_CNT, 8'hFF);
    ext_cycles(1);
    rd_chk("R7 ovf flag", A_ST, 8'hF0);
    rd_chk("R7 wrapped", A_CNT, 8'h00);
  endtask

  task automatic t_protocol;
    wr(A_ST, 8'hFF);
    wr(A_ST, 8'h00);
    rd_chk("R9 unarmed write keeps flags", A_ST, 8'hF0);
    wr(A_ST, 8'h80);
    rd_chk("R9 armed clear of A and ovf", A_ST, 8'h90);
    wr(A_ST, 8'h00);
    rd_chk("R9 armed clear of B", A_ST, 8'h10);
  endtask

  task automatic t_setwins;
    wr(A_CNT, 8'hFF);
    ext_cycles(1);
    rd_chk("R7 ovf again", A_ST, 8'h30);
    wr(A_CNT, 8'hFF);
    @(negedge clk) ext_clk = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_ST, 8'h00);
    rd_chk("R10 set beats clear", A_ST, 8'h30);
    rd_chk("R10 count wrapped", A_CNT, 8'h00);
    @(negedge clk) ext_clk = 1'b0;
    repeat (4) @(posedge clk);
    rd_chk("R9 rearm", A_ST, 8'h30);
    wr(A_ST, 8'h00);
    rd_chk("R9 cleared", A_ST, 8'h10);
  endtask

  task automatic t_output;
    wr(A_CA, 8'd2); wr(A_CB, 8'd4);
    wr(A_ST, 8'h06);
    wr(A_CNT, 8'h00); ext_cycles(2);
    chk("R11 A drive high", {7'b0, tmr_out}, 8'h01);
    ext_cycles(2);
    chk("R11 B drive low", {7'b0, tmr_out}, 8'h00);
    wr(A_ST, 8'h03);
    wr(A_CNT, 8'h00); ext_cycles(2);
    chk("R11 A toggle", {7'b0, tmr_out}, 8'h01);
    ext_cycles(2);
    chk("R11 B keep", {7'b0, tmr_out}, 8'h01);
    wr(A_CNT, 8'h00); ext_cycles(2);
    chk("R11 A toggle back", {7'b0, tmr_out}, 8'h00);
    wr(A_CA, 8'd6); wr(A_CB, 8'd6);
    wr(A_ST, 8'h09);
    wr(A_CNT, 8'd5); ext_cycles(1);
    chk("R11 both match B wins", {7'b0, tmr_out}, 8'h01);
    wr(A_ST, 8'h01);
    wr(A_CNT, 8'd5); ext_cycles(1);
    chk("R11 both match B keep so A", {7'b0, tmr_out}, 8'h00);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_stop();
    t_internal();
    t_ext();
    t_cmp_ovf();
    t_protocol();
    t_setwins();
    t_output();
    summary();
    $finish;
  end
endmodule